// File: doc/BRIEF.md
# Error Counter Snapshot Controller

This block keeps a set of running error tallies, one per error source, and copies them into host-visible holding registers whenever an update is requested. Each error source delivers single-cycle pulses (for example code violations, framing errors or parity errors). The running tallies count these pulses and stop at their maximum value. The holding registers give software a consistent view of the counts over one measurement interval.

An update request is formed from two sources. One is a software control bit, which takes effect only while an enable bit is high. The other is a hardware update pin. The two are ORed together, and only a low-to-high change of the combined signal starts a snapshot. When a snapshot runs, each running tally is moved into its holding register and restarts from zero in the same clock. A one-cycle `done` pulse marks the moment the holding registers carry the new values.

Top module: `errcnt_snapshot`

## Requirements
- R1: After reset, every holding register reads 0, and `busy` and `done` are low.
- R2: Each cycle in which `err_evt[i]` is high adds exactly one to running tally `i`. Several sources may pulse in the same cycle.
- R3: A running tally that has reached all-ones stays at all-ones. It does not wrap.
- R4: A snapshot starts only on a 0-to-1 change of the combined request. A request held high does not start another snapshot. A new snapshot needs the request to fall and rise again.
- R5: `upd_bit` has no effect while `auto_en` is low. `upd_pin` works regardless of `auto_en`.
- R6: The combined request is (`upd_bit` AND `auto_en`) OR `upd_pin`. While one source holds it high, changes of the other source do not start a snapshot.
- R7: In the snapshot clock, each holding register takes the tally counted up to that clock, and the tally restarts. An event in that same clock becomes the first count (value 1) of the new interval.
- R8: `busy` is high for exactly the one cycle that follows the clock edge at which a request rise is sampled. `done` is high for exactly the following cycle. The holding registers are therefore readable two clocks (20 ns at 100 MHz) after the request rises, which is well inside 100 ns.
- R9: `rd_data` shows holding register `rd_addr` combinationally for addresses 0 to NUM_CNT-1. Any other address reads 0.
- R10: Holding registers change only in the clock that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_evt | input | NUM_CNT | Single-cycle error pulses, one per source |
| upd_bit | input | 1 | Software update control bit |
| auto_en | input | 1 | Enable for the software update bit |
| upd_pin | input | 1 | Hardware update input |
| rd_addr | input | AW | Holding register select |
| rd_data | output | CNT_W | Selected holding register |
| busy | output | 1 | Snapshot in progress |
| done | output | 1 | Holding registers were just updated |

## Verification
The hardest case to reach from the ports is an error pulse that lands exactly in the snapshot clock. To hit it, the bench raises `upd_bit` on one falling edge and drives the event pulse on the next falling edge, so the pulse is sampled at the same edge that fires the snapshot. A second snapshot then has to read back 1 on that source.

Saturation is reached by building the block with 6-bit tallies and injecting more than 63 pulses. Overlapping requests from the software bit and the pin are sequenced so that one source keeps the combined request high while the other source toggles.

// File: rtl/errcnt_snapshot.sv
module errcnt_snapshot #(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 16,
  localparam int AW     = $clog2(NUM_CNT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] err_evt,
  input  logic               upd_bit,
  input  logic               auto_en,
  input  logic               upd_pin,
  input  logic [AW-1:0]      rd_addr,
  output logic [CNT_W-1:0]   rd_data,
  output logic               busy,
  output logic               done
);

  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] run_q  [NUM_CNT];
  logic [CNT_W-1:0] hold_q [NUM_CNT];
  logic             req_s1, req_s2, done_q;

  wire req_in = (upd_bit & auto_en) | upd_pin;
  wire fire   = req_s1 & ~req_s2;

  assign busy = fire;
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      done_q <= 1'b0;
    end else begin
      req_s1 <= req_in;
      req_s2 <= req_s1;
      done_q <= fire;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q[g]  <= '0;
        hold_q[g] <= '0;
      end else if (fire) begin
        hold_q[g] <= run_q[g];
        run_q[g]  <= err_evt[g] ? CNT_W'(1) : '0;
      end else if (err_evt[g] && run_q[g] != TOP) begin
        run_q[g]  <= run_q[g] + CNT_W'(1);
      end
    end

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && err_evt[g] && run_q[g] != TOP) |=> run_q[g] == $past(run_q[g]) + CNT_W'(1));
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && run_q[g] == TOP) |=> run_q[g] == TOP);
    a_r7_evt_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && err_evt[g]) |=> run_q[g] == CNT_W'(1));
    a_r7_copy: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> hold_q[g] == $past(run_q[g]));
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(hold_q[g]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (rd_addr == AW'(i)) rd_data = hold_q[i];
  end

  a_r8_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_no_level_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_in) && req_in && $past(req_in, 2)) |=> !busy);

endmodule

// File: tb/errcnt_snapshot_tb.sv
module errcnt_snapshot_tb;
  localparam int N  = 3;
  localparam int W  = 6;
  localparam int AW = $clog2(N + 1);
  localparam int MX = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] err_evt = '0;
  logic upd_bit = 0, auto_en = 0, upd_pin = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic busy, done;

  int n_cmp = 0, n_bad = 0, n_done = 0;

  errcnt_snapshot #(.NUM_CNT(N), .CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .upd_bit(upd_bit),
    .auto_en(auto_en), .upd_pin(upd_pin), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done));

  always #5 clk = ~clk;

  // behavioural reference
  int m_cnt [N];
  int m_hold[N];
  bit m_p1, m_p2, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_cnt[i] <= 0; m_hold[i] <= 0; end
      m_p1 <= 0; m_p2 <= 0; m_done <= 0;
    end else begin
      automatic bit req = (upd_bit && auto_en) || upd_pin;
      automatic bit go  = m_p1 && !m_p2;
      m_p1 <= req; m_p2 <= m_p1; m_done <= go;
      for (int i = 0; i < N; i++) begin
        if (go) begin
          m_hold[i] <= m_cnt[i];
          m_cnt[i]  <= err_evt[i] ? 1 : 0;
        end else if (err_evt[i] && m_cnt[i] < MX) m_cnt[i] <= m_cnt[i] + 1;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      automatic int e = (int'(rd_addr) < N) ? m_hold[rd_addr] : 0;
      chk("R8 busy", busy, m_p1 && !m_p2);
      chk("R8 done", done, m_done);
      chk("R9 rd_data", rd_data, e);
      if (done) n_done++;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(logic [N-1:0] mask, int n);
    for (int k = 0; k < n; k++) begin
      step(); err_evt = mask;
      step(); err_evt = '0;
    end
  endtask

  task automatic read_chk(int a, int exp, string req);
    step(); rd_addr = AW'(a);
    #1 chk(req, rd_data, exp);
  endtask

  task automatic host_pulse();
    step(); upd_bit = 1;
    step(3); upd_bit = 0;
    step(2);
  endtask

  initial begin
    int d0;
    step(3);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0);
    rst_n = 1;
    for (int a = 0; a < N; a++) read_chk(a, 0, "R1 hold");

    // R2: counting with mixed patterns
    auto_en = 1;
    pulses(3'b011, 3); pulses(3'b001, 2);
    host_pulse();
    read_chk(0, 5, "R2 ch0"); read_chk(1, 3, "R2 ch1"); read_chk(2, 0, "R2 ch2");
    read_chk(3, 0, "R9 out of range");

    // R4: held level does not retrigger
    d0 = n_done;
    step(); upd_bit = 1;
    step(4); pulses(3'b001, 2); step(5);
    chk("R4 one snapshot while held", n_done - d0, 1);
    read_chk(0, 0, "R4 first snapshot empty");
    upd_bit = 0; step(2); upd_bit = 1; step(4); upd_bit = 0;
    read_chk(0, 2, "R4 re-arm after clear");

    // R5: host bit ignored when disabled, pin still works
    auto_en = 0; d0 = n_done;
    pulses(3'b100, 4);
    host_pulse();
    chk("R5 no snapshot when disabled", n_done - d0, 0);
    read_chk(2, 0, "R5 hold unchanged");
    step(); upd_pin = 1; step(3); upd_pin = 0; step(2);
    chk("R5 pin snapshot", n_done - d0, 1);
    read_chk(2, 4, "R5 pin value");

    // R6: overlapping sources give one request
    auto_en = 1; d0 = n_done;
    step(); upd_bit = 1; step(3); upd_pin = 1; step(3);
    upd_bit = 0; step(3); upd_bit = 1; step(3); upd_pin = 0; upd_bit = 0; step(3);
    chk("R6 single snapshot", n_done - d0, 1);

    // R7: event in the snapshot clock
    pulses(3'b010, 3);
    step(); upd_bit = 1;
    step(); err_evt = 3'b010;
    step(); err_evt = '0; upd_bit = 0;
    step(2);
    read_chk(1, 3, "R7 old interval");
    host_pulse();
    read_chk(1, 1, "R7 event kept");

    // R3: saturation
    pulses(3'b100, MX + 7);
    host_pulse();
    read_chk(2, MX, "R3 saturated");
    read_chk(0, 0, "R10 other hold");

    step(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule